// File: doc/BRIEF.md
# Encoded Dead-Time Inserter

This block turns one reference PWM waveform into a pair of non-overlapping drive signals: a true output that follows the reference and a complementary output that follows its inverse. Whenever the reference changes level, the output that must switch off does so straight away. The output that must switch on waits for a programmable dead time, so a high-side switch and a low-side switch are never driven at once.

The dead time is given as an 8-bit code and counted in ticks of a dead-time clock enable. The code is read piecewise, which gives fine steps for short delays and coarse steps for long ones. The top bits of the code pick a multiplier of 1, 2, 8 or 16 and a base offset. The low bits add to that offset. A down-counter is loaded from the decoded value at every reference edge and counts one step per tick. If the reference changes again before the count runs out, the counter is reloaded and the pending output never asserts.

Each output also has an enable input. The enable masks the output without disturbing the timing held inside the block.

Top module: `deadband_gen`

## Requirements
- R1: After a synchronous active-low reset with `refIn` held low, `trueOut` is 0 and `compOut` equals `compEn`. No delay is pending, and the code value 0 means no dead time.
- R2: With `dtCode[7]`=0, the dead time is `dtCode` ticks.
- R3: With `dtCode[7:6]`=2'b10, the dead time is 2*(64+`dtCode[5:0]`) ticks.
- R4: With `dtCode[7:5]`=3'b110, the dead time is 8*(32+`dtCode[4:0]`) ticks.
- R5: With `dtCode[7:5]`=3'b111, the dead time is 16*(32+`dtCode[4:0]`) ticks.
- R6: A clock edge at which `refIn` is 1 while it was 0 at the previous edge is a rising edge. On a rising edge, `compOut` goes low at that edge. For a dead time of N>0 ticks, `trueOut` goes high at the edge that samples the N-th `dtTick` after the rising edge. A tick sampled at the rising edge itself does not count.
- R7: On a falling edge of `refIn`, `trueOut` goes low at that edge. `compOut` goes high after the dead time, counted as in R6.
- R8: If `refIn` changes again before the dead time has elapsed, the pending output never asserts. The new edge restarts the count.
- R9: The code is sampled only at a reference edge. Changing `dtCode` while a delay runs does not alter that delay.
- R10: With a decoded dead time of 0, the delayed output switches at the same edge at which the other output switches off.
- R11: `trueOut` is the internal true state ANDed with `trueEn`, and `compOut` is the internal complementary state ANDed with `compEn`. The enables act at once and never restart or stretch the dead time.
- R12: `trueOut` and `compOut` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| refIn | input | 1 | Reference PWM waveform |
| dtCode | input | 8 | Encoded dead-time value |
| dtTick | input | 1 | Dead-time clock enable, one pulse per tick |
| trueEn | input | 1 | Enable of the true output |
| compEn | input | 1 | Enable of the complementary output |
| trueOut | output | 1 | True output with delayed rising edge |
| compOut | output | 1 | Complementary output with delayed rising edge |

## Verification
A wrong decoded count or a miscounted tick shows at the ports as a delayed output that rises too early or too late. This appears at the one edge where the count should have expired, so a cycle-by-cycle comparison catches it within the first dead time after the fault. A stale reference register or a missed reload shows as an output that asserts after a too-short pulse, or as both outputs high together. Both show up in the cycle after the offending reference edge. Long codes in each of the four ranges are timed from edge to output, so an error in an offset or a multiplier shows as a count that is off by a fixed amount.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

  localparam int CODE_W  = 8;
  localparam int DELAY_W = 10;

  typedef struct packed {
    logic load;
    logic step;
  } dtStrobe_t;

  function automatic logic [DELAY_W-1:0] decodeDelay(input logic [CODE_W-1:0] code);
    logic [DELAY_W-1:0] base;
    if (!code[7]) begin
      decodeDelay = DELAY_W'(code);
    end else if (!code[6]) begin
      base = DELAY_W'(code[5:0]) + DELAY_W'(64);
      decodeDelay = base << 1;
    end else if (!code[5]) begin
      base = DELAY_W'(code[4:0]) + DELAY_W'(32);
      decodeDelay = base << 3;
    end else begin
      base = DELAY_W'(code[4:0]) + DELAY_W'(32);
      decodeDelay = base << 4;
    end
  endfunction

endpackage

// File: rtl/deadband_path.sv
module deadband_path
  import deadband_pkg::*;
#(
  parameter int CNT_W = DELAY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] dtCode,
  input  dtStrobe_t         strobe,
  output logic              decZero,
  output logic              cntZero,
  output logic              cntOne
);

  logic [DELAY_W-1:0] decoded;
  logic [CNT_W-1:0]   cnt;

  always_comb begin
    decoded = decodeDelay(dtCode);
    decZero = (decoded == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.load) begin
      cnt <= CNT_W'(decoded);
    end else if (strobe.step) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntZero = (cnt == '0);
  assign cntOne  = (cnt == CNT_W'(1));

endmodule

// File: rtl/deadband_ctrl.sv
module deadband_ctrl
  import deadband_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      refIn,
  input  logic      dtTick,
  input  logic      trueEn,
  input  logic      compEn,
  input  logic      decZero,
  input  logic      cntZero,
  input  logic      cntOne,
  output dtStrobe_t strobe,
  output logic      trueOut,
  output logic      compOut
);

  logic refPrev;
  logic trueRaw;
  logic compRaw;
  logic edgeSeen;
  logic expire;

  always_comb begin
    edgeSeen     = refIn ^ refPrev;
    strobe.load  = edgeSeen;
    strobe.step  = !edgeSeen && dtTick && !cntZero;
    expire       = strobe.step && cntOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      trueRaw <= 1'b0;
      compRaw <= 1'b1;
    end else begin
      refPrev <= refIn;
      if (edgeSeen) begin
        if (refIn) begin
          compRaw <= 1'b0;
          trueRaw <= decZero;
        end else begin
          trueRaw <= 1'b0;
          compRaw <= decZero;
        end
      end else if (expire) begin
        if (refPrev) trueRaw <= 1'b1;
        else         compRaw <= 1'b1;
      end
    end
  end

  assign trueOut = trueRaw & trueEn;
  assign compOut = compRaw & compEn;

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
  import deadband_pkg::*;
#(
  parameter int CNT_W = DELAY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic [CODE_W-1:0] dtCode,
  input  logic              dtTick,
  input  logic              trueEn,
  input  logic              compEn,
  output logic              trueOut,
  output logic              compOut
);

  dtStrobe_t strobe;
  logic      decZero;
  logic      cntZero;
  logic      cntOne;

  deadband_path #(.CNT_W(CNT_W)) pathInst (
    .clk     (clk),
    .rstN    (rstN),
    .dtCode  (dtCode),
    .strobe  (strobe),
    .decZero (decZero),
    .cntZero (cntZero),
    .cntOne  (cntOne)
  );

  deadband_ctrl ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refIn),
    .dtTick  (dtTick),
    .trueEn  (trueEn),
    .compEn  (compEn),
    .decZero (decZero),
    .cntZero (cntZero),
    .cntOne  (cntOne),
    .strobe  (strobe),
    .trueOut (trueOut),
    .compOut (compOut)
  );

endmodule

// File: rtl/deadband_chk.sv
module deadband_chk (
  input logic       clk,
  input logic       rstN,
  input logic       refIn,
  input logic [7:0] dtCode,
  input logic       trueEn,
  input logic       compEn,
  input logic       trueOut,
  input logic       compOut
);

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(trueOut && compOut));

  // R6
  rise_comp_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refIn) |=> !compOut);

  // R7
  fall_true_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refIn) |=> !trueOut);

  // R10
  zero_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(refIn) && dtCode == 8'd0) |=> (trueOut == trueEn));

  // R10
  zero_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(refIn) && dtCode == 8'd0) |=> (compOut == compEn));

  // R6
  true_needs_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(trueOut) && $past(trueEn)) |-> $past(refIn));

endmodule

bind deadband_gen deadband_chk chkInst (
  .clk     (clk),
  .rstN    (rstN),
  .refIn   (refIn),
  .dtCode  (dtCode),
  .trueEn  (trueEn),
  .compEn  (compEn),
  .trueOut (trueOut),
  .compOut (compOut)
);

// File: tb/deadband_gen_test.sv
module deadband_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refIn = 1'b0;
  logic [7:0] dtCode = 8'd0;
  logic       dtTick = 1'b0;
  logic       trueEn = 1'b1;
  logic       compEn = 1'b1;
  logic       trueOut;
  logic       compOut;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string phaseTag = "R1";

  // model state
  bit mPrev = 1'b0;
  bit mTrue = 1'b0;
  bit mComp = 1'b1;
  int mRem  = 0;

  always #5 clk = ~clk;

  deadband_gen uut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .dtCode(dtCode), .dtTick(dtTick),
    .trueEn(trueEn), .compEn(compEn), .trueOut(trueOut), .compOut(compOut)
  );

  function automatic int refDelay(input int code);
    if (code < 128)      return code;
    else if (code < 192) return (64 + code % 64) * 2;
    else if (code < 224) return (32 + code % 32) * 8;
    else                 return (32 + code % 32) * 16;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare before update, then advance the model (R12 overlap included).
  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = 1'b0; mTrue = 1'b0; mComp = 1'b1; mRem = 0;
    end else begin
      check(trueOut == (mTrue & trueEn), {phaseTag, " trueOut"}, int'(trueOut), int'(mTrue & trueEn));
      check(compOut == (mComp & compEn), {phaseTag, " compOut"}, int'(compOut), int'(mComp & compEn));
      check(!(trueOut && compOut), "R12 overlap", int'(trueOut && compOut), 0);
      if (refIn != mPrev) begin
        mRem = refDelay(int'(dtCode));
        if (refIn) begin mComp = 1'b0; mTrue = (mRem == 0); end
        else       begin mTrue = 1'b0; mComp = (mRem == 0); end
      end else if (dtTick && mRem > 0) begin
        mRem--;
        if (mRem == 0) begin
          if (mPrev) mTrue = 1'b1; else mComp = 1'b1;
        end
      end
      mPrev = refIn;
    end
  end

  task automatic measureRise(input int code, input string tag);
    int n = 0;
    int exp = refDelay(code) + 1;
    phaseTag = tag;
    @(negedge clk);
    dtCode = code[7:0]; dtTick = 1'b1; refIn = 1'b1;
    do begin
      @(negedge clk); n++;
      if (n == 1) check(!compOut, "R6 comp off", int'(compOut), 0);
    end while (!trueOut && n < 1100);
    check(n == exp, tag, n, exp);
  endtask

  task automatic measureFall(input int code, input string tag);
    int n = 0;
    int exp = refDelay(code) + 1;
    phaseTag = tag;
    @(negedge clk);
    dtCode = code[7:0]; dtTick = 1'b1; refIn = 1'b0;
    do begin
      @(negedge clk); n++;
      if (n == 1) check(!trueOut, "R7 true off", int'(trueOut), 0);
    end while (!compOut && n < 1100);
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(trueOut == 1'b0, "R1 reset trueOut", int'(trueOut), 0);
    check(compOut == 1'b1, "R1 reset compOut", int'(compOut), 1);

    // code ranges, rise and fall paths
    measureRise(8'h00, "R10 zero rise");
    measureFall(8'h00, "R10 zero fall");
    measureRise(8'h05, "R2 code 0x05");
    measureFall(8'h7F, "R2 code 0x7F");
    measureRise(8'h80, "R3 code 0x80");
    measureFall(8'hBF, "R3 code 0xBF");
    measureRise(8'hC0, "R4 code 0xC0");
    measureFall(8'hDF, "R4 code 0xDF");
    measureRise(8'hE0, "R5 code 0xE0");
    measureFall(8'hFF, "R5 code 0xFF");
    measureRise(8'h0C, "R6 code 0x0C");
    measureFall(8'h0C, "R7 code 0x0C");

    // R8: short pulse never asserts the true output
    begin
      bit seen = 1'b0;
      phaseTag = "R8";
      @(negedge clk); dtCode = 8'd20; refIn = 1'b1;
      repeat (5) begin @(negedge clk); if (trueOut) seen = 1'b1; end
      refIn = 1'b0;
      repeat (30) begin @(negedge clk); if (trueOut) seen = 1'b1; end
      check(!seen, "R8 short pulse", int'(seen), 0);
    end

    // R9: code change mid-delay is ignored
    begin
      int n = 0;
      phaseTag = "R9";
      @(negedge clk); dtCode = 8'd30; refIn = 1'b1;
      do begin
        @(negedge clk); n++;
        if (n == 3) dtCode = 8'd0;
      end while (!trueOut && n < 200);
      check(n == 31, "R9 code change mid-delay", n, 31);
    end

    // R11: enable masks without restarting the count
    begin
      phaseTag = "R11";
      @(negedge clk); dtCode = 8'd10; refIn = 1'b0;
      repeat (15) @(negedge clk);
      refIn = 1'b1;
      repeat (4) @(negedge clk);
      trueEn = 1'b0;
      repeat (10) @(negedge clk);
      check(trueOut == 1'b0, "R11 masked", int'(trueOut), 0);
      trueEn = 1'b1;
      #1;
      check(trueOut == 1'b1, "R11 unmasked at once", int'(trueOut), 1);
    end

    // random traffic against the model (R6 R7 R8 R12)
    phaseTag = "R12 random";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      for (int k = 0; k < 8; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dtTick = (lfsr[5:4] != 2'b00);
      if (lfsr[3:0] == 4'd0) refIn = ~refIn;
      dtCode = (lfsr[14:12] == 3'd0) ? {3'b100, lfsr[10:6]} : {3'b000, lfsr[10:6]};
      if (lfsr[15:11] == 5'd0) trueEn = ~trueEn;
      if (lfsr[15:11] == 5'd1) compEn = ~compEn;
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule